// File: doc/BRIEF.md
# Multi-lane SPI frame shifter

This block moves one serial frame between a parallel data word and up to four SPI data lanes. A sequencer that owns the serial clock sends it one-cycle strobes for the leading and trailing clock edges. The shifter decides on which edge it samples and on which it advances, so clock generation stays outside. A 20-bit format word selects how the frame is shaped: one, two or four lanes, bit order, transmit-only or receive, and a frame length of up to eight bits. The format is taken on the start pulse and held until the frame ends.

The outgoing word is split into groups of one, two or four bits, one group per serial clock. The frame therefore takes ceil(length/lanes) clocks. The returned groups are joined back into a word that follows the same bit order. In dual and quad modes the lanes carry data one way only, so the block drives a per-lane output enable. A transmit-only frame drives the enables and discards what comes back. A receive frame in those modes releases every lane. A one-cycle done pulse marks the end of each frame. A valid strobe with the received word is given alongside it, for the receive store.

Top module: `spi_frame_shifter`

## Requirements
- R1: The format word is decoded as follows: bits 1:0 give the lane mode (0 = one lane, 1 = two lanes, 2 = four lanes, and the unused code 3 behaves as one lane). Bit 2 set means least-significant bit first. Bit 3 set means transmit-only. Bits 19:16 give the length. All other bits have no effect.
- R2: The frame length is 1 to 8 bits. A length field of 0 or above 8 is treated as 8. Only the low `length` bits of the transmit word are sent, and the received word has zeros above `length`.
- R3: After a start pulse, `busy` is high from the next cycle until the final sample. A frame with k lanes takes exactly ceil(length/k) samples.
- R4: Transmit bits form a stream in order. With most-significant bit first, stream bit i is word bit length-1-i. With least-significant bit first, it is word bit i. During clock g, lane j carries stream bit g*k+(k-1-j). Stream positions past the length are sent as 0.
- R5: In one-lane mode the block drives only lane 0 (`dq_oe` = 0001 while busy) and samples lane 1.
- R6: Output enables depend on the mode. In two- or four-lane transmit-only frames, the enables are 0011 or 1111. In two- or four-lane receive frames, all enables are 0. When idle, all enables are 0. A lane whose enable is low outputs 0.
- R7: With phase 0 the block samples on the leading strobe and advances on the trailing strobe. With phase 1 it ignores the first leading strobe, advances on each later leading strobe, and samples on the trailing strobe.
- R8: Received groups are placed in stream order using the same lane mapping as transmit. The word is then rebuilt in the selected bit order, and padding bits of the last group are dropped.
- R9: `frame_done` is high for exactly one cycle: the cycle after the final sample strobe. In a receive frame, `rx_valid` is high in that same cycle and `rx_word` holds the new word.
- R10: In a transmit-only frame, `rx_valid` stays low and `rx_word` keeps its previous value.
- R11: The format, phase and transmit word are captured on the start pulse. Changes to them while busy, and start pulses while busy, have no effect on the frame.
- R12: After reset, and while idle, edge strobes have no effect: `busy`, `frame_done`, `rx_valid`, `dq_oe` and `rx_word` are all 0 after reset, and they stay unchanged under idle strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_word | input | 20 | Frame format word |
| cpha | input | 1 | Clock phase select, captured at start |
| start | input | 1 | Begin a frame (ignored while busy) |
| tx_word | input | 8 | Parallel word to transmit |
| lead_edge | input | 1 | Leading serial clock edge strobe |
| trail_edge | input | 1 | Trailing serial clock edge strobe |
| dq_in | input | 4 | Lane input values |
| dq_out | output | 4 | Lane output values |
| dq_oe | output | 4 | Per-lane output enable |
| busy | output | 1 | Frame in progress |
| rx_word | output | 8 | Last received word |
| rx_valid | output | 1 | Received word written this cycle |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Some properties are checked by assertions on every cycle. These cover the enable patterns per mode and while idle, the single-cycle done pulse and its link to the fall of `busy`, the bound on the sample counter, the format held for the whole frame, and the rule that the received word changes only with `rx_valid` and never in a transmit-only frame. Other behaviour can only be shown by the bench's scenarios. The bench sweeps every lane mode, bit order, direction, phase and length from 1 to 8. In each case it acts as the far device, checking each lane against the arithmetic stream model and returning its own stream with non-zero padding. That is how lane ordering, padding removal, the skipped first leading edge in phase 1, length clamping and the effect of late format or start changes are shown.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  localparam int unsigned SHF_DATA_W = 8;
  localparam int unsigned SHF_LANES  = 4;
  localparam int unsigned SHF_LEN_W  = $clog2(SHF_DATA_W + 1);

  localparam logic [1:0] MODE_X1 = 2'd0;
  localparam logic [1:0] MODE_X2 = 2'd1;
  localparam logic [1:0] MODE_X4 = 2'd2;

  typedef struct packed {
    logic [1:0]           mode;
    logic                 lsb_first;
    logic                 tx_only;
    logic                 cpha;
    logic [SHF_LEN_W-1:0] len;
  } shf_cfg_t;

  function automatic int unsigned lane_step(input logic [1:0] mode);
    case (mode)
      MODE_X2: lane_step = 2;
      MODE_X4: lane_step = 4;
      default: lane_step = 1;
    endcase
  endfunction

  function automatic logic [SHF_DATA_W-1:0] len_mask(input logic [SHF_LEN_W-1:0] len);
    len_mask = ~({SHF_DATA_W{1'b1}} << len);
  endfunction
endpackage

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_shift_pkg::*;
#(
  parameter int unsigned FMT_W   = 20,
  parameter int unsigned LEN_LSB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FMT_W-1:0] fmt_word,
  input  logic             cpha_i,
  input  logic             lead,
  input  logic             trail,
  output shf_cfg_t         cfg_new,
  output shf_cfg_t         cfg_q,
  output logic             busy,
  output logic             load,
  output logic             sample_en,
  output logic             shift_en,
  output logic             last,
  output logic             done
);
  localparam int unsigned NC_W = SHF_LEN_W + 1;

  logic                 busy_q, busy_d, done_q, done_d;
  logic [SHF_LEN_W-1:0] scnt_q, scnt_d;
  shf_cfg_t             cfg_d;
  logic [SHF_LEN_W-1:0] len_raw;
  logic [NC_W-1:0]      nclk;
  logic                 unused_fmt;

  assign unused_fmt = ^fmt_word;
  assign len_raw    = fmt_word[LEN_LSB +: SHF_LEN_W];

  always_comb begin
    cfg_new.mode      = (fmt_word[1:0] == 2'd3) ? MODE_X1 : fmt_word[1:0];
    cfg_new.lsb_first = fmt_word[2];
    cfg_new.tx_only   = fmt_word[3];
    cfg_new.cpha      = cpha_i;
    if (len_raw == '0 || len_raw > SHF_LEN_W'(SHF_DATA_W))
      cfg_new.len = SHF_LEN_W'(SHF_DATA_W);
    else
      cfg_new.len = len_raw;
  end

  always_comb begin
    case (cfg_q.mode)
      MODE_X2: nclk = ({1'b0, cfg_q.len} + NC_W'(1)) >> 1;
      MODE_X4: nclk = ({1'b0, cfg_q.len} + NC_W'(3)) >> 2;
      default: nclk = {1'b0, cfg_q.len};
    endcase
  end

  assign load      = start & ~busy_q;
  assign sample_en = busy_q & (cfg_q.cpha ? trail : lead);
  assign shift_en  = busy_q & (cfg_q.cpha ? (lead & (scnt_q != '0)) : trail);
  assign last      = sample_en & ({1'b0, scnt_q} == nclk - NC_W'(1));

  always_comb begin
    busy_d = busy_q;
    scnt_d = scnt_q;
    cfg_d  = cfg_q;
    done_d = last;
    if (load) begin
      busy_d = 1'b1;
      scnt_d = '0;
      cfg_d  = cfg_new;
    end else if (sample_en) begin
      scnt_d = scnt_q + SHF_LEN_W'(1);
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      scnt_q <= '0;
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      scnt_q <= scnt_d;
      cfg_q  <= cfg_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_busy_fall_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  assert_scnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ({1'b0, scnt_q} < nclk));
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(cfg_q));
endmodule

// File: rtl/spi_tx_lanes.sv
module spi_tx_lanes
  import spi_shift_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  shift_en,
  input  logic                  busy,
  input  shf_cfg_t              cfg_new,
  input  shf_cfg_t              cfg_q,
  input  logic [SHF_DATA_W-1:0] tx_word,
  output logic [SHF_LANES-1:0]  dq_out,
  output logic [SHF_LANES-1:0]  dq_oe
);
  logic [SHF_DATA_W-1:0] sh_q, sh_d, masked;
  logic [SHF_LANES-1:0]  lane_bits, oe_mask;
  int unsigned           step;
  logic                  unused_cfg;

  assign unused_cfg = ^{cfg_new, cfg_q};
  assign step       = lane_step(cfg_q.mode);
  assign masked     = tx_word & len_mask(cfg_new.len);

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      if (cfg_new.lsb_first) sh_d = masked;
      else                   sh_d = masked << (SHF_DATA_W - int'(cfg_new.len));
    end else if (shift_en) begin
      if (cfg_q.lsb_first) sh_d = sh_q >> step;
      else                 sh_d = sh_q << step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  for (genvar j = 0; j < SHF_LANES; j++) begin : g_lane
    always_comb begin
      lane_bits[j] = 1'b0;
      if (j < step) begin
        if (cfg_q.lsb_first) lane_bits[j] = sh_q[step - 1 - j];
        else                 lane_bits[j] = sh_q[SHF_DATA_W - step + j];
      end
    end
  end

  always_comb begin
    case (cfg_q.mode)
      MODE_X2: oe_mask = cfg_q.tx_only ? 4'b0011 : 4'b0000;
      MODE_X4: oe_mask = cfg_q.tx_only ? 4'b1111 : 4'b0000;
      default: oe_mask = 4'b0001;
    endcase
  end

  assign dq_oe  = busy ? oe_mask : '0;
  assign dq_out = lane_bits & dq_oe;

  assert_oe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dq_oe == '0));
  assert_single_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_q.mode == MODE_X1) |-> (dq_oe == 4'b0001));
  assert_rx_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_q.mode != MODE_X1 && !cfg_q.tx_only) |-> (dq_oe == '0));
endmodule

// File: rtl/spi_rx_lanes.sv
module spi_rx_lanes
  import spi_shift_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  sample_en,
  input  logic                  last,
  input  shf_cfg_t              cfg_q,
  input  logic [SHF_LANES-1:0]  dq_in,
  output logic [SHF_DATA_W-1:0] rx_word,
  output logic                  rx_valid
);
  localparam int unsigned ACC_W = SHF_DATA_W + SHF_LANES;
  localparam int unsigned TOT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0]      acc_q, acc_d, acc_new, word_full;
  logic [TOT_W-1:0]      rbits_q, rbits_d, total;
  logic [SHF_DATA_W-1:0] rx_word_q, rx_word_d;
  logic                  rx_valid_q, rx_valid_d;
  logic [SHF_LANES-1:0]  grp, grp_rev;
  int unsigned           step;
  logic                  unused_cfg;

  assign unused_cfg = ^cfg_q;
  assign step       = lane_step(cfg_q.mode);
  assign total      = rbits_q + TOT_W'(step);

  always_comb begin
    case (cfg_q.mode)
      MODE_X2: begin
        grp     = {2'b00, dq_in[1], dq_in[0]};
        grp_rev = {2'b00, dq_in[0], dq_in[1]};
      end
      MODE_X4: begin
        grp     = dq_in;
        grp_rev = {dq_in[0], dq_in[1], dq_in[2], dq_in[3]};
      end
      default: begin
        grp     = {3'b000, dq_in[1]};
        grp_rev = {3'b000, dq_in[1]};
      end
    endcase
  end

  always_comb begin
    if (cfg_q.lsb_first) begin
      acc_new   = (acc_q >> step) | (ACC_W'(grp_rev) << (ACC_W - step));
      word_full = acc_new >> (ACC_W - int'(total));
    end else begin
      acc_new   = (acc_q << step) | ACC_W'(grp);
      word_full = acc_new >> (int'(total) - int'(cfg_q.len));
    end
  end

  always_comb begin
    acc_d      = acc_q;
    rbits_d    = rbits_q;
    rx_word_d  = rx_word_q;
    rx_valid_d = last & ~cfg_q.tx_only;
    if (load) begin
      acc_d   = '0;
      rbits_d = '0;
    end else if (sample_en) begin
      acc_d   = acc_new;
      rbits_d = total;
    end
    if (last && !cfg_q.tx_only)
      rx_word_d = word_full[SHF_DATA_W-1:0] & len_mask(cfg_q.len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      rbits_q    <= '0;
      rx_word_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      acc_q      <= acc_d;
      rbits_q    <= rbits_d;
      rx_word_q  <= rx_word_d;
      rx_valid_q <= rx_valid_d;
    end
  end

  assign rx_word  = rx_word_q;
  assign rx_valid = rx_valid_q;

  assert_rxword_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word_q) |-> rx_valid_q);
  assert_rxvalid_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |-> !cfg_q.tx_only);
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_shift_pkg::*;
#(
  parameter int unsigned FMT_W   = 20,
  parameter int unsigned LEN_LSB = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FMT_W-1:0]      fmt_word,
  input  logic                  cpha,
  input  logic                  start,
  input  logic [SHF_DATA_W-1:0] tx_word,
  input  logic                  lead_edge,
  input  logic                  trail_edge,
  input  logic [SHF_LANES-1:0]  dq_in,
  output logic [SHF_LANES-1:0]  dq_out,
  output logic [SHF_LANES-1:0]  dq_oe,
  output logic                  busy,
  output logic [SHF_DATA_W-1:0] rx_word,
  output logic                  rx_valid,
  output logic                  frame_done
);
  shf_cfg_t cfg_new, cfg_q;
  logic     load, sample_en, shift_en, last;

  spi_shift_ctrl #(.FMT_W(FMT_W), .LEN_LSB(LEN_LSB)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt_word(fmt_word),
    .cpha_i(cpha), .lead(lead_edge), .trail(trail_edge),
    .cfg_new(cfg_new), .cfg_q(cfg_q), .busy(busy), .load(load),
    .sample_en(sample_en), .shift_en(shift_en), .last(last), .done(frame_done)
  );

  spi_tx_lanes tx_i (
    .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en), .busy(busy),
    .cfg_new(cfg_new), .cfg_q(cfg_q), .tx_word(tx_word),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  spi_rx_lanes rx_i (
    .clk(clk), .rst_n(rst_n), .load(load), .sample_en(sample_en), .last(last),
    .cfg_q(cfg_q), .dq_in(dq_in), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  assert_valid_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> frame_done);
endmodule

// File: tb/spi_frame_shifter_tb.sv
`timescale 1ns/1ps
module spi_frame_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] fmt_word = '0;
  logic        cpha = 1'b0, start = 1'b0, lead_edge = 1'b0, trail_edge = 1'b0;
  logic [7:0]  tx_word = '0;
  logic [3:0]  dq_in = '0;
  logic [3:0]  dq_out, dq_oe;
  logic        busy, rx_valid, frame_done;
  logic [7:0]  rx_word;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_frame_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_word(fmt_word), .cpha(cpha), .start(start),
    .tx_word(tx_word), .lead_edge(lead_edge), .trail_edge(trail_edge),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy),
    .rx_word(rx_word), .rx_valid(rx_valid), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit sbit(input logic [7:0] w, input int len, input bit lsb,
                              input int i, input bit pad);
    if (i >= len) return pad;
    return lsb ? w[i] : w[len-1-i];
  endfunction

  task automatic pulse(input bit l, input bit t);
    @(negedge clk); lead_edge = l; trail_edge = t;
    @(negedge clk); lead_edge = 1'b0; trail_edge = 1'b0;
  endtask

  task automatic check_lanes(input string req, input logic [7:0] txw, input int len,
                             input int k, input bit lsb, input logic [3:0] oe_exp,
                             input int g);
    logic [3:0] exp_out;
    for (int j = 0; j < 4; j++)
      exp_out[j] = oe_exp[j] ? sbit(txw, len, lsb, g*k + k - 1 - j, 1'b0) : 1'b0;
    chk(dq_oe == oe_exp, (k == 1) ? "R5" : "R6", "lane enables", dq_oe, oe_exp);
    chk(dq_out == exp_out, req, "lane outputs", dq_out, exp_out);
  endtask

  task automatic drive_rx(input logic [7:0] rxw, input int len, input int k,
                          input bit lsb, input int g);
    dq_in = 4'b1111;
    if (k == 1) dq_in[1] = sbit(rxw, len, lsb, g, 1'b1);
    else for (int j = 0; j < k; j++) dq_in[j] = sbit(rxw, len, lsb, g*k + k - 1 - j, 1'b1);
  endtask

  task automatic run_frame(input logic [1:0] proto, input bit lsb, input bit txo,
                           input bit ph, input logic [3:0] lenf,
                           input logic [7:0] txw, input logic [7:0] rxw,
                           input string rtag);
    int len, k, n;
    logic [3:0] oe_exp;
    logic [7:0] prev, exp_rx;
    string lreq;
    len = (lenf == 0 || lenf > 8) ? 8 : int'(lenf);
    k = (proto == 2'd1) ? 2 : (proto == 2'd2) ? 4 : 1;
    n = (len + k - 1) / k;
    oe_exp = (k == 1) ? 4'b0001 : (!txo ? 4'b0000 : (k == 2) ? 4'b0011 : 4'b1111);
    lreq = ph ? "R7" : "R4";
    prev = rx_word;
    @(negedge clk);
    fmt_word = {lenf, 12'hA5C, txo, lsb, proto};
    cpha = ph; tx_word = txw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fmt_word = fmt_word ^ 20'hFFFFF; cpha = ~ph; tx_word = ~txw;
    chk(busy == 1'b1, "R3", "busy after start", busy, 1);
    @(negedge clk); start = 1'b1; tx_word = txw ^ 8'h3C;
    @(negedge clk); start = 1'b0;
    check_lanes("R11", txw, len, k, lsb, oe_exp, 0);
    for (int g = 0; g < n; g++) begin
      if (!ph) begin
        check_lanes(lreq, txw, len, k, lsb, oe_exp, g);
        drive_rx(rxw, len, k, lsb, g);
        if (g == n - 1) begin
          chk(busy == 1'b1, "R3", "busy before last sample", busy, 1);
          chk(frame_done == 1'b0, "R9", "done before last sample", frame_done, 0);
        end
        pulse(1'b1, 1'b0);
        if (g != n - 1) pulse(1'b0, 1'b1);
      end else begin
        pulse(1'b1, 1'b0);
        check_lanes(lreq, txw, len, k, lsb, oe_exp, g);
        drive_rx(rxw, len, k, lsb, g);
        if (g == n - 1) begin
          chk(busy == 1'b1, "R3", "busy before last sample", busy, 1);
          chk(frame_done == 1'b0, "R9", "done before last sample", frame_done, 0);
        end
        pulse(1'b0, 1'b1);
      end
    end
    exp_rx = txo ? prev : (rxw & 8'((1 << len) - 1));
    chk(frame_done == 1'b1, "R9", "done after last sample", frame_done, 1);
    chk(busy == 1'b0, "R3", "busy cleared", busy, 0);
    chk(rx_valid == !txo, txo ? "R10" : "R9", "rx_valid", rx_valid, !txo);
    chk(rx_word == exp_rx,
        txo ? "R10" : (rtag != "") ? rtag : (k == 1) ? "R5" : "R8",
        "received word", rx_word, exp_rx);
    @(negedge clk);
    chk(frame_done == 1'b0 && rx_valid == 1'b0, "R9", "done pulse width",
        {frame_done, rx_valid}, 0);
    if (!ph) pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    chk(busy == 1'b0 && dq_oe == 4'b0 && dq_out == 4'b0 && frame_done == 1'b0,
        "R12", "idle after frame", {busy, dq_oe, dq_out, frame_done}, 0);
    chk(rx_word == exp_rx, "R12", "word held while idle", rx_word, exp_rx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && dq_oe == 0 && frame_done == 0 && rx_valid == 0 && rx_word == 0,
        "R12", "reset state", {busy, dq_oe, frame_done, rx_valid, rx_word}, 0);
    rst_n = 1'b1;
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    chk(busy == 0 && dq_oe == 0 && frame_done == 0 && rx_valid == 0,
        "R12", "idle strobes after reset", {busy, dq_oe, frame_done, rx_valid}, 0);
    for (int p = 0; p < 3; p++)
      for (int l = 0; l < 2; l++)
        for (int d = 0; d < 2; d++)
          for (int c = 0; c < 2; c++)
            for (int n = 1; n <= 8; n++)
              run_frame(2'(p), l[0], d[0], c[0], 4'(n),
                        8'(37*n + 11*p + 5*l + 3*c + 91*d),
                        8'(29*n + 7*p + 13*l + 17*c + 53*d + 100), "");
    run_frame(2'd3, 1'b0, 1'b0, 1'b0, 4'd7, 8'h5B, 8'h6D, "R1");
    run_frame(2'd3, 1'b1, 1'b0, 1'b1, 4'd5, 8'h1E, 8'h13, "R1");
    run_frame(2'd2, 1'b0, 1'b0, 1'b0, 4'd0, 8'hC3, 8'hA7, "R2");
    run_frame(2'd1, 1'b1, 1'b0, 1'b1, 4'd12, 8'h96, 8'h4E, "R2");
    run_frame(2'd0, 1'b0, 1'b0, 1'b0, 4'd15, 8'hF0, 8'h81, "R2");
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule